// File: doc/BRIEF.md
# Multiphase sampler enable controller

This block steers a bank of eight receive sampler paths. Each path is a chain of three sampling registers (initial, intermediate, final), and each register is clocked by one phase of an eight-phase receive clock. The phase clocks are modelled as one-hot phase strobes in a single fast clock domain. The speed mode sets which paths may run and which phase drives each stage. Low speed uses four phases on paths 0 to 3. High speed with four phases folds every odd phase onto the even phase below it and uses only the even paths. High speed with eight phases uses all paths.

Before selection, every path and register that the mode allows is enabled, and the phase-enable vector asks the clock generator for every phase those registers use. An external correlation engine then pulses a done strobe together with the index of the winning path. From that point the block keeps only that path's three registers running. It drops every phase the path does not use, which leaves between one and three phases, and it delivers the path's final-stage bit as retimed data. An unlock request or a change of speed mode returns the block to the pre-selection state.

Top module: `multiphase_sampler_ctrl`

## Requirements
- R1: After reset the block is unlocked in low-speed mode: `path_en`=0x0F, `reg_en`=0x000FFF, `phase_en`=0x0F, `sel_err`=0, `data_vld`=0, and all sampling registers hold 0.
- R2: `speed_mode` 0 (low speed, four phases) while unlocked enables paths 0..3 only, with `reg_en` bits 3n..3n+2 belonging to path n (stage 0 = initial, 2 = final) and `phase_en` = 0x0F. The code 3 behaves exactly like code 0.
- R3: `speed_mode` 1 (high speed, four phases) while unlocked enables only the even paths and their registers, with `phase_en` = 0x55.
- R4: `speed_mode` 2 (high speed, eight phases) while unlocked enables all eight paths, all 24 registers and all eight phases.
- R5: Path n's initial stage uses phase n. Its final stage uses phase 0. Its intermediate stage uses phase 0, except in mode 2 where paths n≥4 use phase n−3, and in mode 1 where that phase is rounded down to even. An enabled stage loads its input (`rx_din` for stage 0, otherwise the previous stage) on an edge where its phase strobe is high.
- R6: A `corr_done` pulse while unlocked, with `unlock` low and `win_idx` allowed in the current mode, locks the block from the next cycle. `path_en` is then one-hot at `win_idx`, only that path's three `reg_en` bits are set, and `phase_en` holds exactly the phases of its stages. Further `corr_done` pulses while locked are ignored.
- R7: A `corr_done` pulse while unlocked whose `win_idx` is not allowed in the current mode raises `sel_err` for exactly the next cycle and leaves the block unlocked.
- R8: `unlock` returns a locked block to the pre-selection enables on the next cycle. While unlocked, `unlock` takes priority over a simultaneous `corr_done`, which is then ignored without error.
- R9: While locked, a `speed_mode` different from the one captured at lock unlocks the block on the next cycle, and the enables follow the new mode.
- R10: While locked, `data_out` equals the selected path's final register. `data_vld` is high in exactly the cycles that follow an edge where the block was locked and the selected path's final-phase strobe was high.
- R11: A disabled sampling register keeps its value regardless of strobes and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| speed_mode | input | 2 | 0 low four-phase, 1 high four-phase, 2 high eight-phase, 3 as 0 |
| corr_done | input | 1 | Correlation finished strobe |
| win_idx | input | 3 | Index of the winning path |
| unlock | input | 1 | Synchronous return to pre-selection |
| phase_stb | input | 8 | One-hot phase strobes |
| rx_din | input | 1 | Serial receive data |
| path_en | output | 8 | Per-path enable |
| reg_en | output | 24 | Per-register enable, bit 3n+s = path n stage s |
| phase_en | output | 8 | Phase requests to the clock generator |
| sel_err | output | 1 | Rejected winner index, one-cycle pulse |
| data_out | output | 1 | Final-stage bit of the selected path |
| data_vld | output | 1 | data_out was loaded on the previous edge |

## Verification
While unlocked, the enables follow `speed_mode` in the same cycle. Lock, unlock, the mode-change release and the `sel_err` pulse all appear one cycle after the edge that sees the request. A sampled bit reaches `data_out` with `data_vld` one cycle after its final-phase strobe. The bench drives inputs on the falling edge and keeps a behavioural model, advanced on the rising edge, of each register, the lock state and the error pulse. It compares every output with the model on the next falling edge, so each result is read in the cycle it is due, and it adds fixed literal checks for the lock phase sets, the priority cases and a held register.

// File: rtl/msc_pkg.sv
package msc_pkg;
  localparam int NPATH  = 8;
  localparam int NSTAGE = 3;
  localparam int NPHASE = 8;
  localparam int IDX_W  = $clog2(NPATH);
  localparam int PH_W   = $clog2(NPHASE);
  localparam int NREG   = NPATH * NSTAGE;
  localparam int HALF   = NPATH / 2;
  localparam int SKEW   = HALF - 1;

  typedef enum logic [1:0] {
    MODE_LS4 = 2'd0,
    MODE_HS4 = 2'd1,
    MODE_HS8 = 2'd2,
    MODE_RSV = 2'd3
  } spd_mode_e;

  function automatic logic path_allowed(spd_mode_e m, logic [IDX_W-1:0] p);
    case (m)
      MODE_HS8: return 1'b1;
      MODE_HS4: return ~p[0];
      default:  return (int'(p) < HALF);
    endcase
  endfunction

  function automatic logic [PH_W-1:0] stage_phase(spd_mode_e m, logic [IDX_W-1:0] p, int s);
    logic [PH_W-1:0] ph;
    if (s == 0)
      ph = PH_W'(p);
    else if (s == NSTAGE - 1 || m == MODE_LS4 || m == MODE_RSV)
      ph = '0;
    else
      ph = (int'(p) >= HALF) ? PH_W'(int'(p) - SKEW) : '0;
    if (m == MODE_HS4) ph[0] = 1'b0;
    return ph;
  endfunction
endpackage

// File: rtl/msc_lock_ctrl.sv
module msc_lock_ctrl
  import msc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  spd_mode_e        mode_i,
  input  logic             corr_done,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             unlock,
  output logic             locked_q,
  output logic [IDX_W-1:0] sel_q,
  output spd_mode_e        mode_q,
  output logic             err_q
);
  logic             locked_d, err_d, ld;
  logic [IDX_W-1:0] sel_d;
  spd_mode_e        mode_d;

  always_comb begin
    locked_d = locked_q;
    sel_d    = sel_q;
    mode_d   = mode_q;
    err_d    = 1'b0;
    if (locked_q) begin
      if (unlock || mode_i != mode_q) locked_d = 1'b0;
    end else if (!unlock && corr_done) begin
      if (path_allowed(mode_i, win_idx)) begin
        locked_d = 1'b1;
        sel_d    = win_idx;
        mode_d   = mode_i;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  assign ld = (locked_d != locked_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      sel_q    <= '0;
      mode_q   <= MODE_LS4;
      err_q    <= 1'b0;
    end else begin
      err_q <= err_d;
      if (ld) begin
        locked_q <= locked_d;
        sel_q    <= sel_d;
        mode_q   <= mode_d;
      end
    end
  end

  p_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && unlock) |=> !locked_q);
  p_mode_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && mode_i != mode_q) |=> !locked_q);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !unlock && mode_i == mode_q) |=> (locked_q && $stable(sel_q)));
  p_err_no_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !locked_q);
endmodule

// File: rtl/msc_enable_map.sv
module msc_enable_map
  import msc_pkg::*;
(
  input  logic                       locked,
  input  logic [IDX_W-1:0]           sel,
  input  spd_mode_e                  mode,
  output logic [NPATH-1:0]           path_en,
  output logic [NREG-1:0]            reg_en,
  output logic [NPHASE-1:0]          phase_en,
  output logic [NREG-1:0][PH_W-1:0]  ph_map
);
  always_comb begin
    path_en  = '0;
    reg_en   = '0;
    phase_en = '0;
    ph_map   = '0;
    for (int p = 0; p < NPATH; p++) begin
      logic on;
      on = locked ? (IDX_W'(p) == sel) : path_allowed(mode, IDX_W'(p));
      path_en[p] = on;
      for (int s = 0; s < NSTAGE; s++) begin
        ph_map[p*NSTAGE+s] = stage_phase(mode, IDX_W'(p), s);
        reg_en[p*NSTAGE+s] = on;
        if (on) phase_en[ph_map[p*NSTAGE+s]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/msc_path.sv
module msc_path
  import msc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         din,
  input  logic [NPHASE-1:0]            phase_stb,
  input  logic [NSTAGE-1:0]            reg_en,
  input  logic [NSTAGE-1:0][PH_W-1:0]  ph,
  output logic                         q_final
);
  logic [NSTAGE-1:0] st_q, st_d, cap;

  always_comb begin
    st_d = {st_q[NSTAGE-2:0], din};
    for (int s = 0; s < NSTAGE; s++) cap[s] = reg_en[s] & phase_stb[ph[s]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      for (int s = 0; s < NSTAGE; s++)
        if (cap[s]) st_q[s] <= st_d[s];
    end
  end

  assign q_final = st_q[NSTAGE-1];

  p_off_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en == '0) |=> $stable(st_q));
endmodule

// File: rtl/multiphase_sampler_ctrl.sv
module multiphase_sampler_ctrl
  import msc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        speed_mode,
  input  logic              corr_done,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic              unlock,
  input  logic [NPHASE-1:0] phase_stb,
  input  logic              rx_din,
  output logic [NPATH-1:0]  path_en,
  output logic [NREG-1:0]   reg_en,
  output logic [NPHASE-1:0] phase_en,
  output logic              sel_err,
  output logic              data_out,
  output logic              data_vld
);
  localparam logic [NPATH-1:0] ODD_MASK = {HALF{2'b10}};

  logic [1:0]                rst_sync_q;
  logic                      rst_int_n;
  spd_mode_e                 mode_i, mode_q, eff_mode;
  logic                      locked_q, vld_d, vld_q;
  logic [IDX_W-1:0]          sel_q;
  logic [NREG-1:0][PH_W-1:0] ph_map;
  logic [NPATH-1:0]          path_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign mode_i   = spd_mode_e'(speed_mode);
  assign eff_mode = locked_q ? mode_q : mode_i;

  msc_lock_ctrl u_lock (
    .clk(clk), .rst_n(rst_int_n), .mode_i(mode_i), .corr_done(corr_done),
    .win_idx(win_idx), .unlock(unlock), .locked_q(locked_q), .sel_q(sel_q),
    .mode_q(mode_q), .err_q(sel_err)
  );

  msc_enable_map u_map (
    .locked(locked_q), .sel(sel_q), .mode(eff_mode), .path_en(path_en),
    .reg_en(reg_en), .phase_en(phase_en), .ph_map(ph_map)
  );

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    msc_path u_path (
      .clk(clk), .rst_n(rst_int_n), .din(rx_din), .phase_stb(phase_stb),
      .reg_en(reg_en[g*NSTAGE +: NSTAGE]), .ph(ph_map[g*NSTAGE +: NSTAGE]),
      .q_final(path_q[g])
    );
  end

  assign vld_d = locked_q & phase_stb[stage_phase(mode_q, sel_q, NSTAGE-1)];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) vld_q <= 1'b0;
    else            vld_q <= vld_d;
  end

  assign data_vld = vld_q;
  assign data_out = path_q[sel_q];

  p_lock_regs_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    locked_q |-> ($countones(reg_en) == NSTAGE && $onehot(path_en)));
  p_lock_phase_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    locked_q |-> ($countones(phase_en) >= 1 && $countones(phase_en) <= NSTAGE && phase_en[0]));
  p_ls4_upper_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!locked_q && (speed_mode == 2'd0 || speed_mode == 2'd3)) |-> ((path_en >> HALF) == '0));
  p_hs4_odd_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!locked_q && speed_mode == 2'd1) |-> ((path_en & ODD_MASK) == '0));
  p_hs8_all_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!locked_q && speed_mode == 2'd2) |-> (&path_en && &reg_en));
  p_vld_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    data_vld |-> $past(phase_stb[0]));
endmodule

// File: tb/test_multiphase_sampler_ctrl.sv
module test_multiphase_sampler_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  speed_mode;
  logic        corr_done, unlock, rx_din;
  logic [2:0]  win_idx;
  logic [7:0]  phase_stb;
  logic [7:0]  path_en, phase_en;
  logic [23:0] reg_en;
  logic        sel_err, data_out, data_vld;

  int total = 0, bad = 0, cyc_n = 0;
  bit auto_stb = 1'b0;

  // behavioural reference state
  int m_locked, m_sel, m_mode, m_err, m_vld;
  bit m_st[8][3];

  always #5 clk = ~clk;

  multiphase_sampler_ctrl i_multiphase_sampler_ctrl (
    .clk(clk), .rst_n(rst_n), .speed_mode(speed_mode), .corr_done(corr_done),
    .win_idx(win_idx), .unlock(unlock), .phase_stb(phase_stb), .rx_din(rx_din),
    .path_en(path_en), .reg_en(reg_en), .phase_en(phase_en), .sel_err(sel_err),
    .data_out(data_out), .data_vld(data_vld)
  );

  function automatic int f_allowed(int m, int p);
    if (m == 2) return 1;
    if (m == 1) return (p % 2 == 0);
    return (p < 4);
  endfunction

  function automatic int f_phase(int m, int p, int s);
    int mid;
    if (s == 0) return p;
    if (s == 2) return 0;
    mid = (p >= 4) ? p - 3 : 0;
    if (m == 2) return mid;
    if (m == 1) return (mid / 2) * 2;
    return 0;
  endfunction

  function automatic int f_on(int p);
    return m_locked ? (p == m_sel) : f_allowed(int'(speed_mode), p);
  endfunction

  function automatic int f_emode();
    return m_locked ? m_mode : int'(speed_mode);
  endfunction

  function automatic logic [7:0] exp_path();
    logic [7:0] v = '0;
    for (int p = 0; p < 8; p++) v[p] = f_on(p) != 0;
    return v;
  endfunction

  function automatic logic [23:0] exp_reg();
    logic [23:0] v = '0;
    for (int p = 0; p < 8; p++)
      for (int s = 0; s < 3; s++) v[p*3+s] = f_on(p) != 0;
    return v;
  endfunction

  function automatic logic [7:0] exp_phase();
    logic [7:0] v = '0;
    for (int p = 0; p < 8; p++)
      for (int s = 0; s < 3; s++)
        if (f_on(p) != 0) v[f_phase(f_emode(), p, s)] = 1'b1;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_locked = 0; m_sel = 0; m_mode = 0; m_err = 0; m_vld = 0;
      for (int p = 0; p < 8; p++) for (int s = 0; s < 3; s++) m_st[p][s] = 1'b0;
    end else begin
      bit nst[8][3];
      logic [23:0] re;
      int em, nl, ns, nm, ne;
      re = exp_reg();
      em = f_emode();
      for (int p = 0; p < 8; p++)
        for (int s = 0; s < 3; s++) begin
          nst[p][s] = m_st[p][s];
          if (re[p*3+s] && phase_stb[f_phase(em, p, s)])
            nst[p][s] = (s == 0) ? rx_din : m_st[p][(s == 0) ? 0 : s - 1];
        end
      m_vld = (m_locked != 0 && phase_stb[f_phase(m_mode, m_sel, 2)]) ? 1 : 0;
      nl = m_locked; ns = m_sel; nm = m_mode; ne = 0;
      if (m_locked != 0) begin
        if (unlock || int'(speed_mode) != m_mode) nl = 0;
      end else if (!unlock && corr_done) begin
        if (f_allowed(int'(speed_mode), int'(win_idx)) != 0) begin
          nl = 1; ns = int'(win_idx); nm = int'(speed_mode);
        end else ne = 1;
      end
      m_locked = nl; m_sel = ns; m_mode = nm; m_err = ne;
      m_st = nst;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    string et;
    if (m_locked != 0) et = "R6";
    else if (speed_mode == 2'd1) et = "R3";
    else if (speed_mode == 2'd2) et = "R4";
    else et = "R2";
    chk(et, "path_en", 32'(path_en), 32'(exp_path()));
    chk(et, "reg_en", 32'(reg_en), 32'(exp_reg()));
    chk(et, "phase_en", 32'(phase_en), 32'(exp_phase()));
    chk("R7", "sel_err", 32'(sel_err), 32'(m_err));
    chk("R10", "data_vld", 32'(data_vld), 32'(m_vld));
    if (m_locked != 0) chk("R5", "data_out", 32'(data_out), 32'(m_st[m_sel][2]));
  endtask

  task automatic step(input int m, input bit cd, input int idx, input bit un);
    speed_mode = 2'(m); corr_done = cd; win_idx = 3'(idx); unlock = un;
    phase_stb  = auto_stb ? 8'(1 << (cyc_n % 8)) : 8'h00;
    rx_din     = 1'($urandom);
    cyc_n++;
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(input int m, input int n);
    repeat (n) step(m, 1'b0, 0, 1'b0);
  endtask

  initial begin
    bit held;
    rst_n = 1'b0; speed_mode = 2'd0; corr_done = 1'b0; win_idx = '0;
    unlock = 1'b0; phase_stb = '0; rx_din = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run(0, 4);
    // R1 reset state
    chk("R1", "path_en", 32'(path_en), 32'h0F);
    chk("R1", "reg_en", 32'(reg_en), 32'h000FFF);
    chk("R1", "phase_en", 32'(phase_en), 32'h0F);
    chk("R1", "sel_err", 32'(sel_err), 32'h0);
    chk("R1", "data_vld", 32'(data_vld), 32'h0);

    auto_stb = 1'b1;
    run(0, 24);
    run(1, 24);
    chk("R3", "phase_en", 32'(phase_en), 32'h55);
    run(2, 24);
    run(3, 12);
    chk("R2", "mode3 path_en", 32'(path_en), 32'h0F);

    // R7 rejected index in low speed
    step(0, 1'b1, 5, 1'b0);
    chk("R7", "err raised", 32'(sel_err), 32'h1);
    chk("R7", "path_en kept", 32'(path_en), 32'h0F);
    step(0, 1'b0, 0, 1'b0);
    chk("R7", "err single cycle", 32'(sel_err), 32'h0);

    // R6 lock path 2 in low speed
    step(0, 1'b1, 2, 1'b0);
    chk("R6", "ls lock path_en", 32'(path_en), 32'h04);
    chk("R6", "ls lock reg_en", 32'(reg_en), 32'h1C0);
    chk("R6", "ls lock phase_en", 32'(phase_en), 32'h05);
    run(0, 40);
    step(0, 1'b1, 1, 1'b0);
    chk("R6", "strobe ignored", 32'(path_en), 32'h04);
    step(0, 1'b0, 0, 1'b1);
    chk("R8", "unlock path_en", 32'(path_en), 32'h0F);

    // high speed four phase, lock 6, then mode change
    run(1, 8);
    step(1, 1'b1, 6, 1'b0);
    chk("R6", "hs4 phase_en", 32'(phase_en), 32'h45);
    run(1, 32);
    step(2, 1'b0, 0, 1'b0);
    chk("R9", "mode change path_en", 32'(path_en), 32'hFF);

    // high speed eight phase, lock 5
    step(2, 1'b1, 5, 1'b0);
    chk("R6", "hs8 phase_en", 32'(phase_en), 32'h25);
    chk("R6", "hs8 reg_en", 32'(reg_en), 32'h38000);
    run(2, 32);
    step(2, 1'b1, 3, 1'b1);
    chk("R8", "unlock over strobe", 32'(path_en), 32'hFF);
    step(2, 1'b1, 4, 1'b1);
    chk("R8", "priority no lock", 32'(path_en), 32'hFF);
    chk("R8", "priority no err", 32'(sel_err), 32'h0);
    step(2, 1'b1, 0, 1'b0);
    chk("R6", "path0 phase_en", 32'(phase_en), 32'h01);
    run(2, 24);
    step(2, 1'b0, 0, 1'b1);

    // R7 odd index in high speed four phase
    step(1, 1'b1, 3, 1'b0);
    chk("R7", "hs4 odd err", 32'(sel_err), 32'h1);
    run(1, 4);

    // R11 path 5 held while disabled in low speed
    run(0, 32);
    held = m_st[5][2];
    auto_stb = 1'b0;
    run(0, 2);
    step(2, 1'b1, 5, 1'b0);
    chk("R11", "held final reg", 32'(data_out), 32'(held));
    step(2, 1'b0, 0, 1'b1);
    run(2, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(10 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired R1 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule